// File: doc/BRIEF.md
# Dual-Mode External Event Counter

A 16-bit up-counter for a microcontroller peripheral. It takes its count events from one of three sources: the system clock, rising edges of an external count pin that pass through a two-flop synchronizer, or rising edges of that pin with no synchronizer at all. Software controls it through a byte-wide register port. The port has one register per counter byte and one control register. It reads and writes the counter one byte at a time.

In the unsynchronized mode the pin itself clocks a small counter. That counter keeps running while the system clock is stopped for sleep. When the count rolls over, the block requests wake-up without waiting for the system clock. Byte reads in this mode return a value that has been brought safely into the system clock domain. Capture/compare logic cannot use this mode as a time base, so the time-base-valid output is deasserted while it is active.

An operating state machine has four states:

- `ST_STOP`: idle, nothing counts.
- `ST_INTCLK`: counts system clocks.
- `ST_SYNCEXT`: counts synchronized pin edges.
- `ST_ASYNCEXT`: counts raw pin edges.

Every write to the control register moves the machine to the state that the written run, source and no-sync bits select. It may move from any state to any other. When the machine leaves `ST_ASYNCEXT`, the pin-domain count is folded into the stored counter.

Control register bits:

| Bit | Meaning |
|-----|---------|
| 0 | run |
| 1 | external source |
| 2 | no-sync (unsynchronized external counting) |
| 3 | oscillator enable |
| 4 | overflow flag |

Register addresses: 0 is the low byte, 1 is the high byte, 2 is control.

Top module: `dm_event_counter`

## Requirements
- R1: After reset, both counter bytes and the control register read 0, `tb_valid_o` is 1, and `wake_o` and `osc_en_o` are 0.
- R2: While stopped, a write to address 0 or 1 loads that counter byte. The counter holds its value otherwise.
- R3: With control 0x01, the counter advances by one on every clock edge from the edge after the enabling write up to and including the stopping write. It does not advance while `sleep_i` is 1.
- R4: With control 0x03, each rising edge of `ext_cnt_i` adds exactly one, after synchronization. No edge counts while `sleep_i` is 1.
- R5: With control 0x07, rising edges of `ext_cnt_i` are counted even while the system clock is halted.
- R6: In mode 0x07, once the pin has been quiet for three clock cycles, byte reads return the exact count.
- R7: A rollover from 0xFFFF to 0x0000 sets the overflow flag (control bit 4) in every counting mode.
- R8: `wake_o` is 1 whenever the flag is set. It is also 1 as soon as an unsynchronized rollover occurs, even with the clock halted.
- R9: Only a control write with bit 4 = 0 clears the flag; writing 1 leaves it unchanged. A rollover in the same cycle as a clearing write leaves the flag set.
- R10: `tb_valid_o` is 0 while the state is `ST_ASYNCEXT` and 1 in every other state.
- R11: `osc_en_o` follows control bit 3.
- R12: Stopping from mode 0x07 keeps the accumulated count in the counter bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Low-power sleep indication |
| ext_cnt_i | input | 1 | External count pin |
| reg_addr_i | input | 2 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| osc_en_o | output | 1 | Low-power oscillator enable |
| tb_valid_o | output | 1 | Time base usable by capture/compare |
| wake_o | output | 1 | Wake-up request |

## Verification
The hardest case to reach is a rollover in the unsynchronized mode while the system clock is actually stopped. Only there does the wake request have to come from the pin domain alone. The bench gates its own clock generator off, toggles the count pin with plain delays across 0xFFFF, and checks `wake_o` before any clock edge arrives. It then restarts the clock and checks that the flag was transferred and that the folded count is correct. Directed runs also time a flag-clearing write to land on the exact overflow edge.

// File: rtl/dmec_pkg.sv
package dmec_pkg;

    typedef enum logic [1:0] {
        ST_STOP     = 2'd0,
        ST_INTCLK   = 2'd1,
        ST_SYNCEXT  = 2'd2,
        ST_ASYNCEXT = 2'd3
    } dmec_state_e;

    localparam int CB_RUN    = 0;
    localparam int CB_EXTSRC = 1;
    localparam int CB_NOSYNC = 2;
    localparam int CB_OSC    = 3;
    localparam int CB_OVF    = 4;
    localparam int CTRL_KEEP = 4;

endpackage

// File: rtl/dmec_sync.sv
module dmec_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dmec_async_cnt.sv
module dmec_async_cnt #(
    parameter int W = 16
) (
    input  logic         ext_clk_i,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic [W-1:0] base_i,
    output logic [W-1:0] gray_o,
    output logic         wrap_tgl_o
);

    logic         aclr_n;
    logic [W-1:0] bin_q;
    logic [W-1:0] bin_nx;
    logic [W-1:0] gray_q;
    logic [W-1:0] total_nx;
    logic         tgl_q;

    assign aclr_n   = rst_n & run_i;
    assign bin_nx   = bin_q + W'(1);
    assign total_nx = base_i + bin_nx;

    // pin-domain delta, held clear whenever the mode is not active
    always_ff @(posedge ext_clk_i or negedge aclr_n) begin
        if (!aclr_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // one toggle per rollover of base + delta
    always_ff @(posedge ext_clk_i or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (run_i && (total_nx == '0)) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign gray_o     = gray_q;
    assign wrap_tgl_o = tgl_q;

endmodule

// File: rtl/dm_event_counter.sv
module dm_event_counter
    import dmec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(CNT_W / BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              ext_cnt_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [BYTE_W-1:0] reg_wdata_i,
    output logic [BYTE_W-1:0] reg_rdata_o,
    output logic              osc_en_o,
    output logic              tb_valid_o,
    output logic              wake_o
);

    localparam int NLANES = CNT_W / BYTE_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NLANES);

    dmec_state_e        state_q, state_d;
    logic [CTRL_KEEP-1:0] ctrl_q;
    logic               flag_q, flag_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [CNT_W-1:0]   dlt_gray_s, dlt_bin, rd_val;
    logic               ctrl_wr;
    logic               inc_en, arun, tbv, fold;
    logic               lvl_s, prev_q, ext_rise;
    logic               tgl_raw, tgl_s, tgl_ack_q, async_evt, ovf_evt;
    logic [CNT_W-1:0]   gray_raw;
    logic               wdata_unused;

    assign ctrl_wr      = reg_we_i && (reg_addr_i == CTRL_ADDR);
    assign wdata_unused = ^reg_wdata_i[BYTE_W-1:CB_OVF+1];

    // synchronized path for the pin
    dmec_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ext_cnt_i), .q_o(lvl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_s;
    end
    assign ext_rise = lvl_s & ~prev_q;

    // unsynchronized path: counter clocked by the pin itself
    dmec_async_cnt #(.W(CNT_W)) u_acnt (
        .ext_clk_i (ext_cnt_i),
        .rst_n     (rst_n),
        .run_i     (arun),
        .base_i    (cnt_q),
        .gray_o    (gray_raw),
        .wrap_tgl_o(tgl_raw)
    );

    dmec_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_gray_sync (
        .clk(clk), .rst_n(rst_n), .d_i(gray_raw), .q_o(dlt_gray_s)
    );

    dmec_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(tgl_raw), .q_o(tgl_s)
    );

    always_comb begin
        dlt_bin[CNT_W-1] = dlt_gray_s[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) dlt_bin[i] = dlt_bin[i+1] ^ dlt_gray_s[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_ack_q <= 1'b0;
        else        tgl_ack_q <= tgl_s;
    end
    assign async_evt = tgl_s ^ tgl_ack_q;

    // next-state process
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            unique casez ({reg_wdata_i[CB_RUN], reg_wdata_i[CB_EXTSRC], reg_wdata_i[CB_NOSYNC]})
                3'b0??:  state_d = ST_STOP;
                3'b10?:  state_d = ST_INTCLK;
                3'b110:  state_d = ST_SYNCEXT;
                3'b111:  state_d = ST_ASYNCEXT;
                default: state_d = ST_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        inc_en = 1'b0;
        arun   = 1'b0;
        tbv    = 1'b1;
        unique case (state_q)
            ST_STOP:     inc_en = 1'b0;
            ST_INTCLK:   inc_en = ~sleep_i;
            ST_SYNCEXT:  inc_en = ext_rise & ~sleep_i;
            ST_ASYNCEXT: begin
                arun = 1'b1;
                tbv  = 1'b0;
            end
            default:     inc_en = 1'b0;
        endcase
    end

    assign fold    = (state_q == ST_ASYNCEXT) && (state_d != ST_ASYNCEXT);
    assign ovf_evt = inc_en && (cnt_q == '1);

    always_comb begin
        cnt_d = cnt_q;
        if (fold)        cnt_d = cnt_q + dlt_bin;
        else if (inc_en) cnt_d = cnt_q + CNT_W'(1);
        for (int l = 0; l < NLANES; l++) begin
            if (reg_we_i && (reg_addr_i == ADDR_W'(l)))
                cnt_d[l*BYTE_W +: BYTE_W] = reg_wdata_i;
        end
    end

    always_comb begin
        flag_d = flag_q;
        if (ctrl_wr && !reg_wdata_i[CB_OVF]) flag_d = 1'b0;
        if (ovf_evt || async_evt)            flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ctrl_q <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
            if (ctrl_wr) ctrl_q <= reg_wdata_i[CTRL_KEEP-1:0];
        end
    end

    assign rd_val = (state_q == ST_ASYNCEXT) ? (cnt_q + dlt_bin) : cnt_q;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == CTRL_ADDR) begin
            reg_rdata_o[CTRL_KEEP-1:0] = ctrl_q;
            reg_rdata_o[CB_OVF]        = flag_q;
        end else begin
            for (int l = 0; l < NLANES; l++) begin
                if (reg_addr_i == ADDR_W'(l)) reg_rdata_o = rd_val[l*BYTE_W +: BYTE_W];
            end
        end
    end

    assign osc_en_o   = ctrl_q[CB_OSC];
    assign tb_valid_o = tbv;
    assign wake_o     = flag_q | (tgl_raw ^ tgl_ack_q);

endmodule

// File: rtl/dmec_chk.sv
module dmec_chk
    import dmec_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              reg_we_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [BYTE_W-1:0] reg_wdata_i,
    input logic              tb_valid_o,
    input logic              osc_en_o,
    input dmec_state_e       state_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              flag_q
);

    localparam int NLANES = CNT_W / BYTE_W;

    logic             cnt_wr, ctrl_wr;
    logic [CNT_W-1:0] cnt_plus;

    assign cnt_wr   = reg_we_i && (int'(reg_addr_i) < NLANES);
    assign ctrl_wr  = reg_we_i && (int'(reg_addr_i) == NLANES);
    assign cnt_plus = cnt_q + CNT_W'(1);

    p_hold_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !cnt_wr) |=> $stable(cnt_q));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTCLK && !sleep_i && !cnt_wr) |=> (cnt_q == $past(cnt_plus)));

    p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SYNCEXT && sleep_i && !cnt_wr) |=> $stable(cnt_q));

    p_ovf_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INTCLK && !sleep_i && cnt_q == '1) |=> flag_q);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(ctrl_wr && !reg_wdata_i[CB_OVF])) |=> flag_q);

    p_tbv_async_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata_i[CB_RUN] && reg_wdata_i[CB_EXTSRC] && reg_wdata_i[CB_NOSYNC])
        |=> !tb_valid_o);

    p_osc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (osc_en_o == $past(reg_wdata_i[CB_OSC])));

endmodule

bind dm_event_counter dmec_chk #(
    .CNT_W (CNT_W),
    .BYTE_W(BYTE_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .tb_valid_o (tb_valid_o),
    .osc_en_o   (osc_en_o),
    .state_q    (state_q),
    .cnt_q      (cnt_q),
    .flag_q     (flag_q)
);

// File: tb/sim_dm_event_counter.sv
module sim_dm_event_counter;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       sleep_i = 1'b0;
    logic       ext_cnt_i = 1'b0;
    logic [1:0] reg_addr_i = '0;
    logic       reg_we_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       osc_en_o, tb_valid_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;

    always begin
        #10;
        if (clk_run) clk = ~clk;
    end

    dm_event_counter u0 (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .ext_cnt_i(ext_cnt_i),
        .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .osc_en_o(osc_en_o), .tb_valid_o(tb_valid_o),
        .wake_o(wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the following posedge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #2 d = reg_rdata_o;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo); rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic load(input logic [15:0] v);
        wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_cnt_i = 1'b1; repeat (3) @(negedge clk);
            ext_cnt_i = 1'b0; repeat (3) @(negedge clk);
        end
    endtask

    function automatic logic [16:0] expect_sum(input logic [15:0] s, input int k);
        return {1'b0, s} + 17'(k);
    endfunction

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v, s;
        logic [16:0] e;
        void'($urandom(32'h5eed_0c47));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, b); chk("R1 low byte", b, 8'h00);
        rd(2'd1, b); chk("R1 high byte", b, 8'h00);
        rd(2'd2, b); chk("R1 control", b, 8'h00);
        chk("R1 tb_valid", tb_valid_o, 1'b1);
        chk("R1 wake", wake_o, 1'b0);
        chk("R1 osc", osc_en_o, 1'b0);

        // R11 oscillator enable
        wr(2'd2, 8'h08);
        chk("R11 osc set", osc_en_o, 1'b1);
        rd(2'd2, b); chk("R11 ctrl readback", b, 8'h08);
        wr(2'd2, 8'h00);
        chk("R11 osc clear", osc_en_o, 1'b0);

        // R2 byte loads and hold while stopped
        load(16'h3CA5);
        repeat (5) @(negedge clk);
        rd16(v); chk("R2 load hold", v, 16'h3CA5);

        // R3 / R7 internal clock counting, random vectors
        for (int it = 0; it < 14; it++) begin
            int k;
            s = (it % 3 == 0) ? 16'hFFFF - 16'($urandom_range(0, 30)) : 16'($urandom);
            k = $urandom_range(0, 40);
            wr(2'd2, 8'h00);
            load(s);
            wr(2'd2, 8'h01);
            repeat (k) @(negedge clk);
            wr(2'd2, 8'h10);
            e = expect_sum(s, k + 1);
            rd16(v); chk("R3 internal count", v, e[15:0]);
            rd(2'd2, b); chk("R7 internal flag", b, e[16] ? 8'h10 : 8'h00);
        end

        // R3 no counting while asleep
        wr(2'd2, 8'h00); load(16'h1234);
        sleep_i = 1'b1;
        wr(2'd2, 8'h01);
        repeat (6) @(negedge clk);
        wr(2'd2, 8'h00);
        sleep_i = 1'b0;
        rd16(v); chk("R3 sleep hold", v, 16'h1234);

        // R9 set wins over a simultaneous clear
        load(16'hFFFC);
        wr(2'd2, 8'h01);
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h00);
        rd(2'd2, b); chk("R9 set beats clear", b, 8'h10);
        rd16(v); chk("R7 wrap to zero", v, 16'h0000);
        chk("R8 wake on flag", wake_o, 1'b1);
        wr(2'd2, 8'h10);
        rd(2'd2, b); chk("R9 write one keeps", b, 8'h10);
        wr(2'd2, 8'h00);
        rd(2'd2, b); chk("R9 write zero clears", b, 8'h00);
        chk("R8 wake drops", wake_o, 1'b0);

        // R4 synchronized external edges, random vectors
        for (int it = 0; it < 5; it++) begin
            int n;
            s = (it == 4) ? 16'hFFFE : 16'($urandom);
            n = (it == 4) ? 3 : $urandom_range(1, 7);
            wr(2'd2, 8'h00); load(s);
            wr(2'd2, 8'h03);
            chk("R10 tb_valid in sync mode", tb_valid_o, 1'b1);
            repeat (3) @(negedge clk);
            pulses(n);
            repeat (4) @(negedge clk);
            wr(2'd2, 8'h10);
            e = expect_sum(s, n);
            rd16(v); chk("R4 sync count", v, e[15:0]);
            rd(2'd2, b); chk("R7 sync flag", b, e[16] ? 8'h10 : 8'h00);
        end

        // R4 sync mode ignores edges while asleep
        wr(2'd2, 8'h00); load(16'h0777);
        sleep_i = 1'b1;
        wr(2'd2, 8'h03);
        repeat (3) @(negedge clk);
        pulses(3);
        repeat (4) @(negedge clk);
        wr(2'd2, 8'h00);
        sleep_i = 1'b0;
        rd16(v); chk("R4 sleep no count", v, 16'h0777);

        // R5 / R6 / R10 / R12 unsynchronized counting with clock running
        for (int it = 0; it < 3; it++) begin
            int n;
            s = 16'($urandom);
            n = $urandom_range(1, 9);
            wr(2'd2, 8'h00); load(s);
            repeat (3) @(negedge clk);
            wr(2'd2, 8'h07);
            chk("R10 tb_valid low in async", tb_valid_o, 1'b0);
            repeat (3) @(negedge clk);
            pulses(n);
            repeat (4) @(negedge clk);
            e = expect_sum(s, n);
            rd16(v); chk("R6 read while running", v, e[15:0]);
            wr(2'd2, 8'h10);
            rd16(v); chk("R12 value kept after stop", v, e[15:0]);
            chk("R10 tb_valid back after stop", tb_valid_o, 1'b1);
        end

        // R5 / R8 rollover with the system clock halted
        wr(2'd2, 8'h00); load(16'hFFF8);
        repeat (3) @(negedge clk);
        wr(2'd2, 8'h07);
        repeat (4) @(negedge clk);
        sleep_i = 1'b1;
        clk_run = 1'b0;
        #5;
        chk("R8 no wake before rollover", wake_o, 1'b0);
        for (int i = 0; i < 10; i++) begin
            ext_cnt_i = 1'b1; #25;
            ext_cnt_i = 1'b0; #25;
        end
        chk("R8 wake with clock halted", wake_o, 1'b1);
        clk_run = 1'b1;
        @(negedge clk);
        sleep_i = 1'b0;
        repeat (5) @(negedge clk);
        rd16(v); chk("R5 count during sleep", v, 16'h0002);
        rd(2'd2, b); chk("R7 async flag", b, 8'h17);
        wr(2'd2, 8'h17);
        rd(2'd2, b); chk("R9 keep in async", b, 8'h17);
        wr(2'd2, 8'h07);
        rd(2'd2, b); chk("R9 clear in async", b, 8'h07);
        chk("R8 wake cleared", wake_o, 1'b0);
        wr(2'd2, 8'h10);
        rd16(v); chk("R12 fold after sleep", v, 16'h0002);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule